// File: doc/BRIEF.md
# Packed SIMD Integer Compare and Add Unit

This block is one execute stage for a slice of a three-register vector integer instruction class. It receives a 32-bit instruction word and decodes the lane width, the full- or half-vector flag, the unsigned/alternate selector and the two source register indices. The indices go straight out to an external 32-entry, 128-bit vector register file. The two operand vectors it returns are processed lane by lane in the same cycle.

It implements modular add and subtract, signed and unsigned greater-than, signed and unsigned greater-or-equal, bit test and equality. Lanes can be 8, 16, 32 or 64 bits wide. One clock edge after a valid instruction, the unit presents a destination write or raises one of two flags. The first flag marks an encoding that is unallocated. The second marks an allocated encoding that this unit does not implement. When the half-vector form is used, only the low 64 bits are computed and the upper 64 bits of the written value are zero.

Top module: `simd_cmpadd_unit`

## Requirements
- R1: The source indices come from instruction bits 9:5 (first source) and 20:16 (second source) and appear combinationally on the index outputs. The destination index comes from bits 4:0 and appears with the write. Other decoded fields: Q at bit 30, U at bit 29, lane size at bits 23:22 (0=8, 1=16, 2=32, 3=64 bits) and opcode at bits 15:11.
- R2: Opcode 0x10 adds each lane modulo the lane width when U=0. When U=1 it subtracts each lane (first source minus second).
- R3: Opcode 0x06 tests first source greater than second, as two's-complement values when U=0 and as unsigned values when U=1.
- R4: Opcode 0x07 tests first source greater than or equal to second, signed when U=0 and unsigned when U=1.
- R5: Opcode 0x11 with U=1 tests the two lanes for equality. With U=0 it is true when the bitwise AND of the two lanes is nonzero.
- R6: A compare lane is written as all ones when true and all zeros when false.
- R7: With Q=1 all 128 bits are processed. With Q=0 only the low 64 bits are processed and the upper 64 bits of the written value are zero.
- R8: Lane size 3 with Q=0 is unallocated for every opcode. It raises the unallocated flag and no write occurs.
- R9: Lane size 3 is unallocated for opcodes 0x00, 0x02, 0x04, 0x0C, 0x0D, 0x0E, 0x0F, 0x12 and 0x13 even with Q=1. Opcode 0x13 with U=1 is also unallocated for any nonzero size.
- R10: An allocated encoding whose opcode is not 0x06, 0x07, 0x10 or 0x11 raises the unsupported flag and no write occurs. At most one of write, unallocated and unsupported is active in any cycle, and unallocated takes priority.
- R11: Write, unallocated and unsupported outputs are registered. Each is a one-cycle pulse on the edge after a valid instruction, and all are low after reset and after a cycle without a valid instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_valid | input | 1 | Instruction word is valid this cycle |
| insn | input | 32 | Instruction word |
| src_n_idx | output | 5 | First source register index |
| src_m_idx | output | 5 | Second source register index |
| src_n_val | input | 128 | First source vector from register file |
| src_m_val | input | 128 | Second source vector from register file |
| wr_en | output | 1 | Destination write strobe |
| wr_idx | output | 5 | Destination register index |
| wr_val | output | 128 | Destination write value |
| undef_flag | output | 1 | Unallocated encoding pulse |
| unsup_flag | output | 1 | Allocated but unimplemented encoding pulse |

## Verification
The decode can meet two classifications at once. An opcode outside the implemented set, such as 0x00 or 0x13, can also carry an unallocated size, and then the unallocated flag alone must fire with no write and no unsupported pulse. The bench provokes this with directed encodings and with random words whose opcodes are drawn from the whole 5-bit space, and it judges the result against its own classification table. Upper-half clearing likewise coincides with every narrow compare and arithmetic result, so each Q=0 write is checked for both its lane values and its zero upper half.

// File: rtl/simd_pkg.sv
package simd_pkg;

  localparam int IDX_W  = 5;
  localparam int INSN_W = 32;

  typedef enum logic [1:0] {
    OP_ADDSUB = 2'd0,
    OP_GT     = 2'd1,
    OP_GE     = 2'd2,
    OP_TSTEQ  = 2'd3
  } lane_op_e;

  typedef struct packed {
    logic             q;
    logic             u;
    logic [1:0]       size;
    logic [4:0]       opc;
    logic [IDX_W-1:0] rm;
    logic [IDX_W-1:0] rn;
    logic [IDX_W-1:0] rd;
  } insn_fields_t;

  // unallocated-encoding rule for the three-register integer class
  function automatic logic unalloc_rule(insn_fields_t f);
    logic wide = (f.size == 2'd3);
    case (f.opc)
      5'h13:                          return wide || (f.u && f.size != 2'd0);
      5'h00, 5'h02, 5'h04,
      5'h0c, 5'h0d, 5'h0e, 5'h0f,
      5'h12:                          return wide;
      default:                        return wide && !f.q;
    endcase
  endfunction

endpackage

// File: rtl/simd_decode.sv
module simd_decode
  import simd_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output insn_fields_t      fld,
  output lane_op_e          op,
  output logic              is_unalloc,
  output logic              is_unsup
);
  logic impl_hit;
  logic unused_bits;

  assign unused_bits = ^{insn[31], insn[28:24], insn[21], insn[10]};

  assign fld.q    = insn[30];
  assign fld.u    = insn[29];
  assign fld.size = insn[23:22];
  assign fld.opc  = insn[15:11];
  assign fld.rm   = insn[20:16];
  assign fld.rn   = insn[9:5];
  assign fld.rd   = insn[4:0];

  always_comb begin
    impl_hit = 1'b1;
    op       = OP_ADDSUB;
    case (fld.opc)
      5'h06:   op = OP_GT;
      5'h07:   op = OP_GE;
      5'h10:   op = OP_ADDSUB;
      5'h11:   op = OP_TSTEQ;
      default: impl_hit = 1'b0;
    endcase
  end

  assign is_unalloc = unalloc_rule(fld);
  assign is_unsup   = !is_unalloc && !impl_hit;

  // R10
  always_comb begin
    class_excl_chk: assert (!(is_unalloc && is_unsup));
  end
endmodule

// File: rtl/simd_lane_alu.sv
module simd_lane_alu
  import simd_pkg::*;
#(
  parameter int VEC_W  = 128,
  parameter int LANE_W = 8
) (
  input  lane_op_e         op,
  input  logic             u,
  input  logic [VEC_W-1:0] a,
  input  logic [VEC_W-1:0] b,
  output logic [VEC_W-1:0] res
);
  localparam int NLANE = VEC_W / LANE_W;
  localparam logic [LANE_W-1:0] SIGN_BIT = {1'b1, {(LANE_W-1){1'b0}}};

  // signed order is obtained by flipping the sign bit, then comparing unsigned
  function automatic logic [LANE_W-1:0] lane_calc(lane_op_e o, logic uu,
                                                  logic [LANE_W-1:0] x,
                                                  logic [LANE_W-1:0] y);
    logic [LANE_W-1:0] kx = uu ? x : (x ^ SIGN_BIT);
    logic [LANE_W-1:0] ky = uu ? y : (y ^ SIGN_BIT);
    logic hit;
    case (o)
      OP_GT:    hit = (kx > ky);
      OP_GE:    hit = (kx >= ky);
      OP_TSTEQ: hit = uu ? (x == y) : ((x & y) != '0);
      default:  hit = 1'b0;
    endcase
    if (o == OP_ADDSUB) return uu ? (x - y) : (x + y);
    return {LANE_W{hit}};
  endfunction

  for (genvar i = 0; i < NLANE; i++) begin : g_lane
    logic [LANE_W-1:0] slice;
    assign slice = lane_calc(op, u, a[i*LANE_W +: LANE_W], b[i*LANE_W +: LANE_W]);
    assign res[i*LANE_W +: LANE_W] = slice;

    // R6
    always_comb begin
      if (op != OP_ADDSUB) begin
        lane_mask_chk: assert (slice == '0 || slice == '1);
      end
    end
  end
endmodule

// File: rtl/simd_cmpadd_unit.sv
module simd_cmpadd_unit
  import simd_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  insn_valid,
  input  logic [INSN_W-1:0]     insn,
  output logic [IDX_W-1:0]      src_n_idx,
  output logic [IDX_W-1:0]      src_m_idx,
  input  logic [VEC_W-1:0]      src_n_val,
  input  logic [VEC_W-1:0]      src_m_val,
  output logic                  wr_en,
  output logic [IDX_W-1:0]      wr_idx,
  output logic [VEC_W-1:0]      wr_val,
  output logic                  undef_flag,
  output logic                  unsup_flag
);
  localparam int HALF_W  = VEC_W / 2;
  localparam int N_SIZES = 4;

  insn_fields_t fld;
  lane_op_e     op;
  logic         dec_unalloc;
  logic         dec_unsup;
  logic         narrow_q;
  logic [VEC_W-1:0] res_by_size [N_SIZES];
  logic [VEC_W-1:0] res_sel;
  logic [VEC_W-1:0] res_clip;

  simd_decode u_dec (
    .insn       (insn),
    .fld        (fld),
    .op         (op),
    .is_unalloc (dec_unalloc),
    .is_unsup   (dec_unsup)
  );

  assign src_n_idx = fld.rn;
  assign src_m_idx = fld.rm;

  for (genvar s = 0; s < N_SIZES; s++) begin : g_size
    simd_lane_alu #(.VEC_W(VEC_W), .LANE_W(8 << s)) u_alu (
      .op  (op),
      .u   (fld.u),
      .a   (src_n_val),
      .b   (src_m_val),
      .res (res_by_size[s])
    );
  end

  assign res_sel  = res_by_size[fld.size];
  assign res_clip = fld.q ? res_sel : {{HALF_W{1'b0}}, res_sel[HALF_W-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_en      <= 1'b0;
      undef_flag <= 1'b0;
      unsup_flag <= 1'b0;
      wr_idx     <= '0;
      wr_val     <= '0;
      narrow_q   <= 1'b0;
    end else begin
      wr_en      <= insn_valid && !dec_unalloc && !dec_unsup;
      undef_flag <= insn_valid && dec_unalloc;
      unsup_flag <= insn_valid && dec_unsup;
      wr_idx     <= fld.rd;
      wr_val     <= res_clip;
      narrow_q   <= !fld.q;
    end
  end

  // R7
  narrow_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && narrow_q) |-> (wr_val[VEC_W-1:HALF_W] == '0));

  // R8
  unalloc_narrow64_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && insn[23:22] == 2'b11 && !insn[30]) |=> (undef_flag && !wr_en));

  // R10
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({wr_en, undef_flag, unsup_flag}) <= 1);

  // R11
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    insn_valid |=> (wr_en || undef_flag || unsup_flag));

  // R11
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !insn_valid |=> !(wr_en || undef_flag || unsup_flag));
endmodule

// File: tb/simd_cmpadd_unit_tb.sv
module simd_cmpadd_unit_tb;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         insn_valid;
  logic [31:0]  insn;
  logic [4:0]   src_n_idx, src_m_idx, wr_idx;
  logic [127:0] src_n_val, src_m_val, wr_val;
  logic         wr_en, undef_flag, unsup_flag;

  int total = 0;
  int bad   = 0;

  logic [127:0] rf [32];
  logic         poke_en = 1'b0;
  logic [4:0]   poke_idx = '0;
  logic [127:0] poke_val = '0;

  always #10 clk = ~clk;

  simd_cmpadd_unit u_dut (
    .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn(insn),
    .src_n_idx(src_n_idx), .src_m_idx(src_m_idx),
    .src_n_val(src_n_val), .src_m_val(src_m_val),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_val(wr_val),
    .undef_flag(undef_flag), .unsup_flag(unsup_flag)
  );

  // bench-side register file
  assign src_n_val = rf[src_n_idx];
  assign src_m_val = rf[src_m_idx];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) rf[i] <= {$urandom, $urandom, $urandom, $urandom};
    end else if (poke_en) begin
      rf[poke_idx] <= poke_val;
    end else if (wr_en) begin
      rf[wr_idx] <= wr_val;
    end
  end

  task automatic chk(bit ok, string req, logic [127:0] act, logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(bit q, bit u, logic [1:0] sz, logic [4:0] opc,
                                     logic [4:0] rm, logic [4:0] rn, logic [4:0] rd);
    return {1'b0, q, u, 5'b01110, sz, 1'b1, rm, opc, 1'b1, rn, rd};
  endfunction

  // 0 = write, 1 = unallocated, 2 = unsupported
  function automatic int ref_class(logic [31:0] w);
    logic [4:0] opc = w[15:11];
    bit big = (w[23:22] == 2'd3);
    bit und;
    if (opc == 5'd19)                         und = big || (w[29] && w[23:22] != 0);
    else if (opc inside {5'd0, 5'd2, 5'd4, 5'd12, 5'd13, 5'd14, 5'd15, 5'd18}) und = big;
    else                                       und = big && !w[30];
    if (und) return 1;
    if (!(opc inside {5'd6, 5'd7, 5'd16, 5'd17})) return 2;
    return 0;
  endfunction

  function automatic logic [127:0] ref_vec(logic [31:0] w, logic [127:0] a, logic [127:0] b);
    int lw = 8 << w[23:22];
    int n  = (w[30] ? 128 : 64) / lw;
    logic [127:0] r = '0;
    for (int i = 0; i < n; i++) begin
      logic [63:0] mk64, x, y, z;
      longint sx, sy;
      bit hit, is_cmp;
      mk64 = (lw == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << lw) - 64'd1);
      x = 64'(a >> (i * lw)) & mk64;
      y = 64'(b >> (i * lw)) & mk64;
      sx = x[lw-1] ? longint'(x | ~mk64) : longint'(x);
      sy = y[lw-1] ? longint'(y | ~mk64) : longint'(y);
      is_cmp = 1'b1;
      hit = 1'b0;
      z = '0;
      case (w[15:11])
        5'h10: begin z = (w[29] ? (x - y) : (x + y)) & mk64; is_cmp = 1'b0; end
        5'h06: hit = w[29] ? (x > y) : (sx > sy);
        5'h07: hit = w[29] ? (x >= y) : (sx >= sy);
        default: hit = w[29] ? (x == y) : ((x & y) != 0);
      endcase
      if (is_cmp) z = hit ? mk64 : 64'd0;
      r = r | (128'(z) << (i * lw));
    end
    return r;
  endfunction

  task automatic poke(logic [4:0] idx, logic [127:0] v);
    @(negedge clk);
    poke_en = 1'b1; poke_idx = idx; poke_val = v;
    @(negedge clk);
    poke_en = 1'b0;
  endtask

  task automatic run(logic [31:0] w);
    logic [127:0] ev;
    int cls;
    string rq;
    logic [2:0] eflags;
    @(negedge clk);
    insn = w; insn_valid = 1'b1;
    ev  = ref_vec(w, rf[w[9:5]], rf[w[20:16]]);
    cls = ref_class(w);
    #1;
    chk(src_n_idx == w[9:5] && src_m_idx == w[20:16], "R1 src idx",
        {src_n_idx, src_m_idx}, {w[9:5], w[20:16]});
    @(negedge clk);
    insn_valid = 1'b0;
    eflags = (cls == 0) ? 3'b100 : (cls == 1) ? 3'b010 : 3'b001;
    if (cls == 1) rq = (w[23:22] == 2'd3 && !w[30]) ? "R8 class" : "R9 class";
    else if (cls == 2) rq = "R10 class";
    else rq = "R11 class";
    chk({wr_en, undef_flag, unsup_flag} == eflags, rq,
        {wr_en, undef_flag, unsup_flag}, eflags);
    if (cls == 0) begin
      chk(wr_idx == w[4:0], "R1 dest idx", wr_idx, w[4:0]);
      case (w[15:11])
        5'h10:   rq = "R2 addsub";
        5'h06:   rq = "R3/R6 gt";
        5'h07:   rq = "R4/R6 ge";
        default: rq = "R5/R6 tst/eq";
      endcase
      chk(wr_val == ev, rq, wr_val, ev);
      if (!w[30]) chk(wr_val[127:64] == '0, "R7 upper clear", wr_val[127:64], 128'd0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [4:0] impl_ops [4];
    impl_ops[0] = 5'h06; impl_ops[1] = 5'h07; impl_ops[2] = 5'h10; impl_ops[3] = 5'h11;
    void'($urandom(32'd20240607));
    rst_n = 1'b0; insn_valid = 1'b0; insn = '0;
    repeat (3) @(negedge clk);
    chk({wr_en, undef_flag, unsup_flag} == 3'b000, "R11 reset", {wr_en, undef_flag, unsup_flag}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({wr_en, undef_flag, unsup_flag} == 3'b000, "R11 idle", {wr_en, undef_flag, unsup_flag}, 0);

    // directed operands
    poke(5'd1, {16{8'h80}});
    poke(5'd2, {16{8'h7F}});
    poke(5'd3, {16{8'hFF}});
    poke(5'd4, {16{8'h01}});
    poke(5'd5, {4{32'h8000_0000}});
    poke(5'd6, {2{64'h8000_0000_0000_0001}});
    poke(5'd7, {2{64'h7FFF_FFFF_FFFF_FFFF}});

    run(mk(1, 0, 2'd0, 5'h06, 5'd2, 5'd1, 5'd10)); // R3 signed 0x80 > 0x7F false
    run(mk(1, 1, 2'd0, 5'h06, 5'd2, 5'd1, 5'd11)); // R3 unsigned true
    run(mk(1, 0, 2'd0, 5'h07, 5'd1, 5'd1, 5'd12)); // R4 equal operands
    run(mk(1, 0, 2'd0, 5'h10, 5'd4, 5'd3, 5'd13)); // R2 byte wrap
    run(mk(1, 1, 2'd1, 5'h10, 5'd3, 5'd4, 5'd14)); // R2 16-bit borrow
    run(mk(1, 0, 2'd0, 5'h11, 5'd2, 5'd1, 5'd15)); // R5 test false
    run(mk(1, 1, 2'd2, 5'h11, 5'd5, 5'd5, 5'd16)); // R5 equality true
    run(mk(0, 0, 2'd2, 5'h10, 5'd3, 5'd3, 5'd17)); // R7 narrow add
    run(mk(1, 0, 2'd3, 5'h07, 5'd7, 5'd6, 5'd18)); // R4 64-bit signed
    run(mk(1, 1, 2'd3, 5'h06, 5'd7, 5'd6, 5'd19)); // R3 64-bit unsigned
    run(mk(0, 0, 2'd3, 5'h10, 5'd3, 5'd4, 5'd20)); // R8
    run(mk(0, 1, 2'd3, 5'h08, 5'd3, 5'd4, 5'd20)); // R8 over unimplemented opcode
    run(mk(1, 0, 2'd3, 5'h00, 5'd3, 5'd4, 5'd20)); // R9 overlap with unsupported
    run(mk(1, 1, 2'd1, 5'h13, 5'd3, 5'd4, 5'd20)); // R9
    run(mk(1, 0, 2'd1, 5'h13, 5'd3, 5'd4, 5'd20)); // R10
    run(mk(1, 0, 2'd3, 5'h01, 5'd3, 5'd4, 5'd20)); // R10
    run(mk(0, 0, 2'd2, 5'h0c, 5'd3, 5'd4, 5'd20)); // R10

    // constrained random mix
    for (int k = 0; k < 500; k++) begin
      logic [31:0] w = $urandom;
      if (($urandom % 10) < 8) w[15:11] = impl_ops[$urandom % 4];
      run(w);
    end

    @(negedge clk);
    chk({wr_en, undef_flag, unsup_flag} == 3'b000, "R11 idle end", {wr_en, undef_flag, unsup_flag}, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule